// File: doc/BRIEF.md
# Power-Fail Host Access Gate

The gate sits between a host bus front end and a clock/RAM core. It watches a digital supply-good level and decides, cycle by cycle, whether host chip-select, read and write strobes may reach the core. It also produces the enable for the read-data output drivers. When the supply drops, access closes in the same cycle. A write that is still in flight is then cut off before it can touch the core, and the data drivers float.

When the supply comes back, the gate checks the oscillator status. If the oscillator is stopped, the gate raises a one-cycle request to set the oscillator enable and opens access on the next cycle, with no delay. If the oscillator is running, the gate opens access only after a recovery delay of `TREC` reference ticks. That delay counts only while the countdown chain is out of reset. Holding the chain in reset, or losing the supply, starts the count again from zero. The reference tick passes through to the timekeeping core without any gating, so time keeps advancing while access is blocked.

Top module: `pwr_access_gate`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `access_ok`, `osc_en_set`, `core_cs`, `core_wr`, `core_rd` and `bus_oe` are all 0.
- R2: In any cycle where `supply_good` is 0, `core_cs`, `core_rd` and `core_wr` are 0, whatever the host inputs are.
- R3: `bus_oe` is 1 only in a cycle where access is granted and the host drives `host_cs` and `host_rd`. It is 0 whenever `supply_good` is 0.
- R4: `core_tick` equals `ref_tick` in every cycle, regardless of the supply and the gate state.
- R5: Suppose `supply_good` rises while `osc_enabled` is 1. Once `TREC` cycles with `ref_tick`=1 and `chain_reset`=0 have been sampled after the first good cycle, `access_ok` becomes 1 on the next cycle, and not before.
- R6: While `chain_reset` is 1 during the recovery delay, access stays closed and the tick count returns to zero.
- R7: If `supply_good` falls during the recovery delay, the count is discarded. A full `TREC` ticks are needed again after the supply returns.
- R8: Suppose `supply_good` is sampled 1 in the first good cycle while `osc_enabled` is 0. Then `osc_en_set` pulses high for exactly one cycle, and `access_ok` is 1 in that same cycle, with no delay.
- R9: A write held on `host_wr` while the supply drops does not reach the core: `core_wr` is 0 in the first cycle in which `supply_good` is 0.
- R10: `access_ok` is 1 exactly when the gate is open and `supply_good` is 1. When it is 1, `core_cs`/`core_rd`/`core_wr` follow the host strobes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_good | input | 1 | Supply-good level from the comparator |
| ref_tick | input | 1 | Reference tick used to count the recovery delay |
| osc_enabled | input | 1 | Oscillator enable status |
| chain_reset | input | 1 | Countdown chain held in reset |
| host_cs | input | 1 | Host chip-select (active high) |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| core_cs | output | 1 | Gated chip-select to the core |
| core_rd | output | 1 | Gated read strobe to the core |
| core_wr | output | 1 | Gated write strobe to the core |
| bus_oe | output | 1 | Read-data driver enable (0 = high impedance) |
| core_tick | output | 1 | Ungated tick to timekeeping |
| osc_en_set | output | 1 | One-cycle request to set the oscillator enable |
| access_ok | output | 1 | Gate state: host access allowed |

## Verification
The bench builds the gate with `TREC` = 5. At that value the full recovery window elapses within a few dozen cycles, so a single run covers many power cycles. It also reaches supply drops at every count value, chain resets that strike partway through the delay, and power-ups with the oscillator both stopped and running. Random supply, tick, status and host patterns run alongside a few directed sequences that check the exact grant cycle and a write that is cut off by a supply drop.

// File: rtl/pwr_access_gate.sv
module pwr_access_gate #(
  parameter int TREC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_good,
  input  logic ref_tick,
  input  logic osc_enabled,
  input  logic chain_reset,
  input  logic host_cs,
  input  logic host_rd,
  input  logic host_wr,
  output logic core_cs,
  output logic core_rd,
  output logic core_wr,
  output logic bus_oe,
  output logic core_tick,
  output logic osc_en_set,
  output logic access_ok
);
  localparam int CW = $clog2(TREC + 1);

  typedef enum logic [1:0] {S_OFF, S_WAIT, S_ON} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic osc_set_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OFF;
      cnt       <= '0;
      osc_set_q <= 1'b0;
    end else begin
      osc_set_q <= 1'b0;
      if (!supply_good) begin
        st  <= S_OFF;
        cnt <= '0;
      end else begin
        case (st)
          S_OFF: begin
            cnt <= '0;
            if (!osc_enabled) begin
              st        <= S_ON;
              osc_set_q <= 1'b1;
            end else begin
              st <= S_WAIT;
            end
          end
          S_WAIT: begin
            if (chain_reset) cnt <= '0;
            else if (ref_tick) begin
              if (cnt == CW'(TREC - 1)) st <= S_ON;
              else cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign access_ok  = (st == S_ON) && supply_good;
  assign core_cs    = host_cs && access_ok;
  assign core_rd    = core_cs && host_rd;
  assign core_wr    = core_cs && host_wr;
  assign bus_oe     = core_rd;
  assign core_tick  = ref_tick;
  assign osc_en_set = osc_set_q;
endmodule

module pwr_access_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_good,
  input logic ref_tick,
  input logic host_wr,
  input logic core_cs,
  input logic core_rd,
  input logic core_wr,
  input logic bus_oe,
  input logic core_tick,
  input logic osc_en_set,
  input logic access_ok
);
  AST_CS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |-> (!core_cs && !core_rd && !core_wr)); // R2
  AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |-> !bus_oe); // R3
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (core_rd && access_ok)); // R3
  AST_TICK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    core_tick == ref_tick); // R4
  AST_OSC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en_set |=> !osc_en_set); // R8
  AST_OSC_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en_set && supply_good) |-> access_ok); // R8
  AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(supply_good) && host_wr) |-> !core_wr); // R9
  AST_GATE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    access_ok |-> supply_good); // R10
endmodule

bind pwr_access_gate pwr_access_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .ref_tick(ref_tick),
  .host_wr(host_wr), .core_cs(core_cs), .core_rd(core_rd), .core_wr(core_wr),
  .bus_oe(bus_oe), .core_tick(core_tick), .osc_en_set(osc_en_set),
  .access_ok(access_ok)
);

// File: tb/tb_pwr_access_gate.sv
module tb_pwr_access_gate;
  localparam int CLK_PERIOD = 10;
  localparam int TREC = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_good = 0, ref_tick = 0, osc_enabled = 1, chain_reset = 0;
  logic host_cs = 0, host_rd = 0, host_wr = 0;
  logic core_cs, core_rd, core_wr, bus_oe, core_tick, osc_en_set, access_ok;

  int checks = 0, failures = 0;
  int m_st = 0;
  int m_cnt = 0;
  bit m_pulse = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_access_gate #(.TREC(TREC)) dut (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_st = 0; m_cnt = 0; m_pulse = 0; end
    else begin
      m_pulse = 0;
      if (!supply_good) begin m_st = 0; m_cnt = 0; end
      else if (m_st == 0) begin
        m_cnt = 0;
        if (!osc_enabled) begin m_st = 2; m_pulse = 1; end else m_st = 1;
      end else if (m_st == 1) begin
        if (chain_reset) m_cnt = 0;
        else if (ref_tick) begin
          if (m_cnt == TREC - 1) m_st = 2; else m_cnt++;
        end
      end
    end
  end

  function automatic bit exp_ok();
    return (m_st == 2) && supply_good;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit ok = exp_ok();
    chk("R10 access_ok", access_ok, ok);
    chk("R2 core_cs", core_cs, ok && host_cs);
    chk("R2 core_rd", core_rd, ok && host_cs && host_rd);
    chk("R9 core_wr", core_wr, ok && host_cs && host_wr);
    chk("R3 bus_oe", bus_oe, ok && host_cs && host_rd);
    chk("R4 core_tick", core_tick, ref_tick);
    chk("R8 osc_en_set", osc_en_set, m_pulse);
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin @(posedge clk); wd++; end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    host_cs = 1; host_rd = 1; host_wr = 1; supply_good = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R1 access_ok", access_ok, 0);
      chk("R1 osc_en_set", osc_en_set, 0);
      chk("R1 core_wr", core_wr, 0);
      chk("R1 bus_oe", bus_oe, 0);
    end
    supply_good = 0;
    rst_n = 1;
    step();
    chk("R1 access_ok after release", access_ok, 0);

    // R5: exact grant cycle with tick every cycle
    osc_enabled = 1; chain_reset = 0; ref_tick = 1; supply_good = 1;
    step();
    for (int i = 0; i < TREC; i++) begin
      chk("R5 closed during delay", access_ok, 0);
      step();
    end
    chk("R5 open after TREC ticks", access_ok, 1);

    // R9: write in flight when supply drops
    host_cs = 1; host_wr = 1; host_rd = 0;
    step();
    chk("R9 write passes while good", core_wr, 1);
    supply_good = 0;
    #1 chk("R9 write aborted on drop", core_wr, 0);
    chk("R3 hi-z on drop", bus_oe, 0);
    step();

    // R7: drop in the middle of the delay
    supply_good = 1;
    for (int i = 0; i < 3; i++) step();
    supply_good = 0; step();
    supply_good = 1;
    for (int i = 0; i < TREC; i++) begin
      step();
      chk("R7 count restarted", access_ok, 0);
    end
    step();
    chk("R7 open after full delay", access_ok, 1);

    // R6: chain reset mid-delay
    supply_good = 0; step(); supply_good = 1;
    for (int i = 0; i < 3; i++) step();
    chain_reset = 1; step(); step();
    chk("R6 closed in chain reset", access_ok, 0);
    chain_reset = 0;
    for (int i = 0; i < TREC - 1; i++) begin
      step();
      chk("R6 count restarted", access_ok, 0);
    end
    step(); step();
    chk("R6 open after full delay", access_ok, 1);

    // R8: oscillator stopped at power-up
    supply_good = 0; step();
    osc_enabled = 0; supply_good = 1; ref_tick = 0;
    step();
    chk("R8 pulse", osc_en_set, 1);
    chk("R8 immediate grant", access_ok, 1);
    osc_enabled = 1;
    step();
    chk("R8 pulse one cycle", osc_en_set, 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      supply_good = ($urandom_range(0, 19) != 0) ? (supply_good | ($urandom_range(0, 3) == 0)) : 1'b0;
      ref_tick    = $urandom_range(0, 1);
      chain_reset = ($urandom_range(0, 14) == 0);
      osc_enabled = ($urandom_range(0, 3) != 0);
      host_cs     = $urandom_range(0, 1);
      host_rd     = $urandom_range(0, 1);
      host_wr     = $urandom_range(0, 1);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule